// File: doc/BRIEF.md
# Audio Frame DMA Channel

This block is a single direct-memory-access channel that moves 16-bit stereo audio frames (four bytes each) between system memory and an audio sample stream. It keeps a current byte address, a count of bytes still to move, and an enable bit. A parameter fixes the direction. In playback, the channel reads memory and hands each word to a stream sink. In capture, it takes words from a stream source and writes them to memory. The register and interrupt behaviour is the same in both directions.

Software programs the address and count while the channel is idle and sets the enable bit. The surrounding logic then offers service opportunities. Each opportunity is a one-cycle start strobe with the number of bytes the stream side can take or supply. The channel moves the smaller of that figure and the remaining count, one 32-bit memory beat per frame. If the stream side stops handshaking partway through, the burst ends early. After each frame the address goes up by four and the count goes down by four. A one-cycle completion pulse marks a service that leaves the count at zero while the channel is enabled.

Top module: `audio_dma_channel`

## Requirements
- R1: After reset the address, count and enable read zero, the channel is not busy, and no memory request, stream handshake or completion pulse is driven.
- R2: A configuration write with select 1 loads the address and with select 2 loads the count, in both cases with the two low bits stored as zero. Select 0 loads enable from data bit 0. Select 3 changes nothing, and every configuration write made while the channel is busy is ignored.
- R3: A service starts only when the channel is idle and enabled. It moves floor(min(count, offered bytes) / 4) frames.
- R4: A service whose frame amount is zero, because the channel is disabled, the count is zero or fewer than 4 bytes are offered, issues no memory request, changes no register and raises no completion pulse.
- R5: In playback each frame is one memory read at the current address, and the word read is presented on the sink. The frame counts as moved only on a sink handshake.
- R6: In capture each frame takes one word from the source on a handshake and writes it to memory at the current address.
- R7: Each moved frame advances the address by 4 and reduces the count by 4. The count never wraps below zero.
- R8: If the stream side does not handshake in a frame's stream cycle, the burst ends at once and only the frames already moved are counted.
- R9: The completion pulse lasts one cycle. It appears in the cycle after the last frame of a service, and only when the channel is enabled and the count is then zero.
- R10: A memory request keeps its address, direction and write data stable until the memory signals ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 enable, 1 address, 2 count, 3 none |
| cfg_wdata | input | ADDR_W | Configuration write data |
| svc_start | input | 1 | One-cycle service opportunity |
| svc_bytes | input | CNT_W | Bytes the stream side can take or supply |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ready |
| mem_ready | input | 1 | Memory accepts or completes the request |
| snk_valid | output | 1 | Playback frame valid |
| snk_ready | input | 1 | Sink accepts frame |
| snk_data | output | 32 | Playback frame |
| src_valid | input | 1 | Capture frame valid |
| src_ready | output | 1 | Channel takes capture frame |
| src_data | input | 32 | Capture frame |
| cur_addr | output | ADDR_W | Current address register |
| remaining | output | CNT_W | Remaining byte count register |
| enabled | output | 1 | Enable bit |
| busy | output | 1 | A service is in progress |
| done_pulse | output | 1 | Completion pulse |

## Verification
A wrong burst length or a missed stall shows up as soon as the service ends. The address and count outputs then differ from the start values by four times the wrong frame number, and the sink or memory sees extra or missing words. A wrong count from earlier services shows as a completion pulse that comes too soon, too late or never. A zero-length service that leaks into the datapath shows as memory-request cycles at once. The bench sweeps enable, starting count, offered bytes, stream stall point and memory latency, and computes every end state arithmetically.

// File: rtl/audio_dma_pkg.sv
package audio_dma_pkg;
   localparam int FRAME_BYTES = 4;
   localparam int WORD_W      = 8 * FRAME_BYTES;

   typedef enum logic [1:0] {
      SEL_CTRL  = 2'd0,
      SEL_ADDR  = 2'd1,
      SEL_COUNT = 2'd2,
      SEL_NONE  = 2'd3
   } cfg_sel_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_MEM  = 2'd1,
      ST_STR  = 2'd2
   } dma_state_t;
endpackage

// File: rtl/audio_dma_regs.sv
module audio_dma_regs
   import audio_dma_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [ADDR_W-1:0] wr_data,
   input  logic              step,
   output logic [ADDR_W-1:0] addr_o,
   output logic [CNT_W-1:0]  rem_o,
   output logic              en_o
);
   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  rem_q;
   logic              en_q;
   logic              unused_wr_bit;

   assign unused_wr_bit = wr_data[1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         rem_q  <= '0;
         en_q   <= 1'b0;
      end else if (wr_en) begin
         case (cfg_sel_t'(wr_sel))
            SEL_CTRL:  en_q   <= wr_data[0];
            SEL_ADDR:  addr_q <= {wr_data[ADDR_W-1:2], 2'b00};
            SEL_COUNT: rem_q  <= {wr_data[CNT_W-1:2], 2'b00};
            default:   ;
         endcase
      end else if (step) begin
         addr_q <= addr_q + ADDR_W'(FRAME_BYTES);
         rem_q  <= rem_q - CNT_W'(FRAME_BYTES);
      end
   end

   assign addr_o = addr_q;
   assign rem_o  = rem_q;
   assign en_o   = en_q;

   AST_STEP_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      step && !wr_en |=> addr_q == $past(addr_q) + ADDR_W'(FRAME_BYTES)); // R7
   AST_STEP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      step && !wr_en |=> rem_q == $past(rem_q) - CNT_W'(FRAME_BYTES)); // R7
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> rem_q != '0); // R7
   AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en && !step |=> $stable(addr_q) && $stable(rem_q) && $stable(en_q)); // R2
endmodule

// File: rtl/audio_dma_engine.sv
module audio_dma_engine
   import audio_dma_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int CNT_W    = 16,
   parameter bit PLAYBACK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [ADDR_W-1:0] cur_addr,
   input  logic [CNT_W-1:0]  rem,
   input  logic              svc_start,
   input  logic [CNT_W-1:0]  svc_bytes,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic [WORD_W-1:0] mem_rdata,
   input  logic              mem_ready,
   output logic              snk_valid,
   input  logic              snk_ready,
   output logic [WORD_W-1:0] snk_data,
   input  logic              src_valid,
   output logic              src_ready,
   input  logic [WORD_W-1:0] src_data,
   output logic              step,
   output logic              busy,
   output logic              done_pulse
);
   localparam int FR_W = CNT_W - 2;

   dma_state_t        state_q, state_d;
   logic [FR_W-1:0]   left_q, left_d;
   logic [WORD_W-1:0] hold_q, hold_d;
   logic              done_q, done_d;
   logic              fin;
   logic [CNT_W-1:0]  amt;
   logic [FR_W-1:0]   frames;
   logic              start;
   logic              unused_amt;

   assign amt        = (rem < svc_bytes) ? rem : svc_bytes;
   assign frames     = amt[CNT_W-1:2];
   assign unused_amt = ^amt[1:0];
   assign start      = (state_q == ST_IDLE) && svc_start && en && (frames != '0);

   generate
      if (PLAYBACK) begin : g_play
         logic unused_src;
         assign unused_src = src_valid ^ (^src_data);
         always_comb begin
            state_d = state_q; left_d = left_q; hold_d = hold_q;
            step = 1'b0; fin = 1'b0;
            mem_req = 1'b0; mem_we = 1'b0; snk_valid = 1'b0; src_ready = 1'b0;
            case (state_q)
               ST_IDLE: if (start) begin left_d = frames; state_d = ST_MEM; end
               ST_MEM: begin
                  mem_req = 1'b1;
                  if (mem_ready) begin hold_d = mem_rdata; state_d = ST_STR; end
               end
               ST_STR: begin
                  snk_valid = 1'b1;
                  if (snk_ready) begin
                     step   = 1'b1;
                     left_d = left_q - 1'b1;
                     if (left_q == FR_W'(1)) begin fin = 1'b1; state_d = ST_IDLE; end
                     else state_d = ST_MEM;
                  end else begin
                     fin = 1'b1; state_d = ST_IDLE;
                  end
               end
               default: state_d = ST_IDLE;
            endcase
         end
      end else begin : g_capt
         logic unused_snk;
         assign unused_snk = snk_ready ^ (^mem_rdata);
         always_comb begin
            state_d = state_q; left_d = left_q; hold_d = hold_q;
            step = 1'b0; fin = 1'b0;
            mem_req = 1'b0; mem_we = 1'b0; snk_valid = 1'b0; src_ready = 1'b0;
            case (state_q)
               ST_IDLE: if (start) begin left_d = frames; state_d = ST_STR; end
               ST_STR: begin
                  src_ready = 1'b1;
                  if (src_valid) begin hold_d = src_data; state_d = ST_MEM; end
                  else begin fin = 1'b1; state_d = ST_IDLE; end
               end
               ST_MEM: begin
                  mem_req = 1'b1;
                  mem_we  = 1'b1;
                  if (mem_ready) begin
                     step   = 1'b1;
                     left_d = left_q - 1'b1;
                     if (left_q == FR_W'(1)) begin fin = 1'b1; state_d = ST_IDLE; end
                     else state_d = ST_STR;
                  end
               end
               default: state_d = ST_IDLE;
            endcase
         end
      end
   endgenerate

   assign done_d = fin && en && (step ? (rem == CNT_W'(FRAME_BYTES)) : (rem == '0));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         left_q  <= '0;
         hold_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         left_q  <= left_d;
         hold_q  <= hold_d;
         done_q  <= done_d;
      end
   end

   assign mem_addr   = cur_addr;
   assign mem_wdata  = hold_q;
   assign snk_data   = hold_q;
   assign busy       = (state_q != ST_IDLE);
   assign done_pulse = done_q;

   AST_ZERO_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE) && svc_start && (!en || rem == '0 || svc_bytes[CNT_W-1:2] == '0)
      |=> (state_q == ST_IDLE) && !done_q); // R4
   AST_START_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(en)); // R3
   AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> en && rem == '0); // R9
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q); // R9
   AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && $stable(mem_wdata)); // R10
endmodule

// File: rtl/audio_dma_channel.sv
module audio_dma_channel
   import audio_dma_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int CNT_W    = 16,
   parameter bit PLAYBACK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [ADDR_W-1:0] cfg_wdata,
   input  logic              svc_start,
   input  logic [CNT_W-1:0]  svc_bytes,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic [31:0]       mem_rdata,
   input  logic              mem_ready,
   output logic              snk_valid,
   input  logic              snk_ready,
   output logic [31:0]       snk_data,
   input  logic              src_valid,
   output logic              src_ready,
   input  logic [31:0]       src_data,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [CNT_W-1:0]  remaining,
   output logic              enabled,
   output logic              busy,
   output logic              done_pulse
);
   generate
      if (CNT_W < 4 || CNT_W > ADDR_W) begin : g_bad_widths
         $error("audio_dma_channel: CNT_W must lie in 4..ADDR_W");
      end
      if (WORD_W != 32) begin : g_bad_frame
         $error("audio_dma_channel: a frame must be one 32-bit word");
      end
   endgenerate

   logic wr_en;
   logic step;

   assign wr_en = cfg_we && !busy;

   audio_dma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (cfg_sel),
      .wr_data (cfg_wdata),
      .step    (step),
      .addr_o  (cur_addr),
      .rem_o   (remaining),
      .en_o    (enabled)
   );

   audio_dma_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PLAYBACK(PLAYBACK)) u_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (enabled),
      .cur_addr   (cur_addr),
      .rem        (remaining),
      .svc_start  (svc_start),
      .svc_bytes  (svc_bytes),
      .mem_req    (mem_req),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .mem_rdata  (mem_rdata),
      .mem_ready  (mem_ready),
      .snk_valid  (snk_valid),
      .snk_ready  (snk_ready),
      .snk_data   (snk_data),
      .src_valid  (src_valid),
      .src_ready  (src_ready),
      .src_data   (src_data),
      .step       (step),
      .busy       (busy),
      .done_pulse (done_pulse)
   );
endmodule

// File: tb/audio_dma_channel_bench.sv
`timescale 1ns/1ps
module audio_dma_channel_bench;
   localparam int AW = 32;
   localparam int CW = 16;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst_n, cfg_we, svc_start, clr;
   logic [1:0]    cfg_sel;
   logic [AW-1:0] cfg_wdata;
   logic [CW-1:0] svc_bytes;

   logic          p_req, p_we, p_ready, p_snk_valid, p_snk_ready, p_src_ready, p_busy, p_done, p_en;
   logic [AW-1:0] p_maddr, p_addr;
   logic [31:0]   p_wdata, p_rdata, p_snk_data;
   logic [CW-1:0] p_rem;
   logic          c_req, c_we, c_ready, c_snk_valid, c_src_valid, c_src_ready, c_busy, c_done, c_en;
   logic [AW-1:0] c_maddr, c_addr;
   logic [31:0]   c_wdata, c_snk_data, c_src_data;
   logic [CW-1:0] c_rem;

   audio_dma_channel #(.ADDR_W(AW), .CNT_W(CW), .PLAYBACK(1'b1)) u_audio_dma_channel (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .svc_start(svc_start), .svc_bytes(svc_bytes),
      .mem_req(p_req), .mem_we(p_we), .mem_addr(p_maddr), .mem_wdata(p_wdata),
      .mem_rdata(p_rdata), .mem_ready(p_ready),
      .snk_valid(p_snk_valid), .snk_ready(p_snk_ready), .snk_data(p_snk_data),
      .src_valid(1'b0), .src_ready(p_src_ready), .src_data(32'h0),
      .cur_addr(p_addr), .remaining(p_rem), .enabled(p_en), .busy(p_busy), .done_pulse(p_done));

   audio_dma_channel #(.ADDR_W(AW), .CNT_W(CW), .PLAYBACK(1'b0)) u_audio_dma_channel_cap (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .svc_start(svc_start), .svc_bytes(svc_bytes),
      .mem_req(c_req), .mem_we(c_we), .mem_addr(c_maddr), .mem_wdata(c_wdata),
      .mem_rdata(32'h0), .mem_ready(c_ready),
      .snk_valid(c_snk_valid), .snk_ready(1'b0), .snk_data(c_snk_data),
      .src_valid(c_src_valid), .src_ready(c_src_ready), .src_data(c_src_data),
      .cur_addr(c_addr), .remaining(c_rem), .enabled(c_en), .busy(c_busy), .done_pulse(c_done));

   // memory models with programmable latency
   int lat = 0;
   logic [2:0] p_wait = '0, c_wait = '0;
   always @(posedge clk) p_wait <= (!p_req || p_ready) ? 3'd0 : p_wait + 3'd1;
   always @(posedge clk) c_wait <= (!c_req || c_ready) ? 3'd0 : c_wait + 3'd1;
   assign p_ready = p_req && (int'(p_wait) >= lat);
   assign c_ready = c_req && (int'(c_wait) >= lat);
   assign p_rdata = p_maddr ^ 32'h5A5A_0000;

   // stream models and observation counters
   int plimit = 0, climit = 0, pacc = 0, csup = 0, cwr = 0, pdone = 0, cdone = 0, pbus = 0, cbus = 0;
   logic [15:0] svc_id = '0;
   logic [31:0] pgot [16];
   logic [31:0] cmem [64];
   assign p_snk_ready = pacc < plimit;
   assign c_src_valid = csup < climit;
   assign c_src_data  = {svc_id, csup[15:0]};

   always @(posedge clk) begin
      if (clr) begin
         pacc <= 0; csup <= 0; cwr <= 0; pdone <= 0; cdone <= 0; pbus <= 0; cbus <= 0;
      end else begin
         if (p_snk_valid && p_snk_ready) begin
            if (pacc < 16) pgot[pacc] <= p_snk_data;
            pacc <= pacc + 1;
         end
         if (c_src_valid && c_src_ready) csup <= csup + 1;
         if (c_req && c_ready && c_we) begin
            cmem[c_maddr[7:2]] <= c_wdata;
            cwr <= cwr + 1;
         end
         if (p_done) pdone <= pdone + 1;
         if (c_done) cdone <= cdone + 1;
         if (p_req) pbus <= pbus + 1;
         if (c_req) cbus <= cbus + 1;
      end
   end

   int nchk = 0, nerr = 0;
   task automatic chk(string req, string what, longint act, longint exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   longint m_addr = 0, m_rem = 0;
   bit m_en = 0;

   task automatic cfg(int sel, longint data, bit model);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel[1:0]; cfg_wdata = data[AW-1:0];
      @(negedge clk);
      cfg_we = 1'b0;
      if (model) begin
         if (sel == 1) m_addr = data & 32'hFFFF_FFFC;
         if (sel == 2) m_rem  = data & 16'hFFFC;
         if (sel == 0) m_en   = data[0];
      end
   endtask

   task automatic service(int bytes, int pl, int cl, bit poke);
      longint a0 = m_addr, r0 = m_rem, amt, fr, pm, cm;
      string tag;
      @(negedge clk);
      clr = 1'b1; plimit = pl; climit = cl; svc_id = svc_id + 16'd1;
      @(negedge clk);
      clr = 1'b0; svc_bytes = bytes[CW-1:0]; svc_start = 1'b1;
      @(negedge clk);
      svc_start = 1'b0;
      if (poke) begin
         cfg(1, 32'h10, 1'b0); cfg(2, 32'h100, 1'b0); cfg(0, 0, 1'b0);
      end
      for (int i = 0; i < 400; i++) begin
         if (!p_busy && !c_busy) break;
         @(negedge clk);
      end
      repeat (2) @(negedge clk);
      amt = m_en ? ((r0 < (bytes & ~3)) ? r0 : (bytes & ~3)) : 0;
      fr = amt / 4;
      pm = (fr < pl) ? fr : pl;
      cm = (fr < cl) ? fr : cl;
      tag = !m_en ? "R3" : (fr == 0 ? "R4" : "R7");
      chk(tag, "play address", p_addr, a0 + 4 * pm);
      chk(tag, "play count", p_rem, r0 - 4 * pm);
      chk(tag, "capt address", c_addr, a0 + 4 * cm);
      chk(tag, "capt count", c_rem, r0 - 4 * cm);
      chk((pm < fr) ? "R8" : "R5", "sink frames", pacc, pm);
      chk((cm < fr) ? "R8" : "R6", "memory writes", cwr, cm);
      for (int i = 0; i < pm; i++)
         chk("R5", "sink data", pgot[i], ((a0 + 4 * i) ^ 32'h5A5A_0000) & 32'hFFFF_FFFF);
      for (int i = 0; i < cm; i++)
         chk("R6", "captured word", cmem[((a0 + 4 * i) >> 2) & 63], {svc_id, i[15:0]});
      chk("R9", "play done pulses", pdone, (fr > 0 && r0 - 4 * pm == 0) ? 1 : 0);
      chk("R9", "capt done pulses", cdone, (fr > 0 && r0 - 4 * cm == 0) ? 1 : 0);
      if (fr == 0) begin
         chk("R4", "play bus cycles", pbus, 0);
         chk("R4", "capt bus cycles", cbus, 0);
      end
      m_addr = a0 + 4 * pm;
      m_rem  = r0 - 4 * pm;
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   endtask

   initial begin
      #(4 * 150000);
      nchk++; nerr++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
      svc_start = 1'b0; svc_bytes = '0; clr = 1'b1;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", "play address", p_addr, 0);
      chk("R1", "play count", p_rem, 0);
      chk("R1", "enable", {p_en, c_en}, 0);
      chk("R1", "busy", {p_busy, c_busy}, 0);
      chk("R1", "done", {p_done, c_done}, 0);
      chk("R1", "bus and stream", {p_req, c_req, p_snk_valid, c_src_ready}, 0);
      rst_n = 1'b1;
      clr = 1'b0;

      // R2 register writes, masking and the unused select
      cfg(1, 32'h0000_0107, 1'b1);
      chk("R2", "address masked", p_addr, 32'h104);
      cfg(2, 32'h0000_002B, 1'b1);
      chk("R2", "count masked", c_rem, 16'h28);
      cfg(0, 32'hFFFF_FFFE, 1'b1);
      chk("R2", "enable bit 0 clear", p_en, 0);
      cfg(0, 1, 1'b1);
      chk("R2", "enable bit 0 set", c_en, 1);
      cfg(3, 32'hFFFF_FFFF, 1'b1);
      chk("R2", "select 3 ignored", {p_addr, p_rem, 15'd0, p_en}, {32'h104, 16'h28, 15'd0, 1'b1});

      // sweep: enable, starting frames, offered bytes, stall points, latency
      for (int en = 0; en < 2; en++)
         for (int rf = 0; rf < 6; rf++)
            for (int b = 0; b <= 24; b += 3)
               for (int li = 0; li < 4; li++) begin
                  int lims [4] = '{0, 1, 2, 7};
                  lat = (rf + b + li) % 3;
                  cfg(1, 32'h40 + 32 * li, 1'b1);
                  cfg(2, 4 * rf, 1'b1);
                  cfg(0, en, 1'b1);
                  service(b, lims[li], lims[(li + 1) % 4], 1'b0);
               end

      // successive services continue from where the last stopped
      lat = 1;
      cfg(1, 32'h40, 1'b1); cfg(2, 24, 1'b1); cfg(0, 1, 1'b1);
      service(100, 2, 2, 1'b0);
      service(100, 8, 8, 1'b0);
      chk("R9", "count drained", p_rem, 0);

      // writes while busy are ignored
      lat = 3;
      cfg(1, 32'h80, 1'b1); cfg(2, 16, 1'b1); cfg(0, 1, 1'b1);
      service(64, 8, 8, 1'b1);
      chk("R2", "enable kept over busy write", {p_en, c_en}, 2'b11);

      finish_run();
   end
endmodule